// File: doc/BRIEF.md
# Line Quality Hysteresis Monitor

This block judges whether a serial receive line is healthy. A symbol decoder upstream raises a one-cycle strobe each time it meets a symbol it cannot decode. The monitor cuts time into back-to-back windows of a fixed number of clock cycles and asks one question per window: did any bad symbol arrive in it? A 3-bit saturating up-down counter gathers those answers. The one-bit line status only flips after a long run of windows that all point the same way, so a single noisy window cannot change it.

After reset the line is treated as bad and the counter sits at its top value. Clean windows walk the counter down. Once it reaches zero, the line is declared good. From then on, windows that contain errors walk the counter up, and the line is declared bad again once it reaches the top value. Each flip of the status produces a one-cycle interrupt request, provided interrupts are enabled. The status also appears at its fixed position in an 8-bit read-only status word, for use by a register bank elsewhere.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `line_quality_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to `line_good`=0, `win_count`=7, `irq`=0 and `status_word`=0, and its window timing restarts.
- R2: A window lasts exactly `WIN_CYCLES` clock edges. Windows follow each other with no gap. The first window starts at the first edge after reset is released. `win_count` changes only at the last edge of a window.
- R3: A window in which `bad_sym` is high on at least one edge increments `win_count` by one, saturating at 7.
- R4: A window with no `bad_sym` decrements `win_count` by one, saturating at 0.
- R5: While the line is bad (`line_good`=0), the status becomes 1 at the window end where `win_count` reaches 0, and the count stays at 0.
- R6: While the line is good, the status becomes 0 at the window end where `win_count` reaches 7, and the count stays at 7.
- R7: With `irq_en`=1, `irq` is high for exactly one cycle, in the same cycle in which `line_good` takes its new value, and it is never high otherwise.
- R8: With `irq_en`=0 at the window's final edge, a status flip raises no `irq`, but the status still changes.
- R9: A `bad_sym` strobe on the final edge of a window counts toward that window only and does not carry into the next one.
- R10: `status_word` bit 6 equals `line_good`, and the other seven bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bad_sym | input | 1 | Strobe from the decoder, high for each undecodable symbol |
| irq_en | input | 1 | Enables the interrupt request on a status flip |
| line_good | output | 1 | Line status: 1 good, 0 bad |
| status_word | output | 8 | Read-only status byte with line status in bit 6 |
| win_count | output | 3 | Hysteresis counter value, for debug |
| irq | output | 1 | One-cycle interrupt request on a status flip |

## Verification
The assertions assume that `rst` is held high for at least one clock edge before any behaviour is judged. They also assume that `irq_en` and `bad_sym` are clean synchronous levels that are sampled on the rising edge. The stimulus changes every input only on the falling clock edge. It opens every run with a reset of two cycles, and it restarts the timing with a reset whenever it leaves window alignment. This way the boundary checks, including the one made by the checker's own cycle counter, always line up with the windows inside the design.

// File: rtl/lqm_pkg.sv
package lqm_pkg;

  typedef enum logic {
    LINE_BAD  = 1'b0,
    LINE_GOOD = 1'b1
  } line_state_e;

  localparam int GOOD_BIT_POS = 6;
  localparam int STATUS_W     = 8;

endpackage

// File: rtl/lqm_window_timer.sv
module lqm_window_timer #(
  parameter int WIN_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  output logic win_last
);
  localparam int TW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(WIN_CYCLES - 1);

  logic [TW-1:0] phase_q;

  assign win_last = (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)           phase_q <= '0;
    else if (win_last) phase_q <= '0;
    else               phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/lqm_hit_tracker.sv
module lqm_hit_tracker (
  input  logic clk,
  input  logic rst,
  input  logic bad_sym,
  input  logic win_last,
  output logic win_hit
);
  logic seen_q;

  // Include the current cycle so a strobe on the closing edge still counts.
  assign win_hit = seen_q | bad_sym;

  always_ff @(posedge clk) begin
    if (rst)           seen_q <= 1'b0;
    else if (win_last) seen_q <= 1'b0;
    else               seen_q <= win_hit;
  end
endmodule

// File: rtl/lqm_hysteresis.sv
module lqm_hysteresis
  import lqm_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_last,
  input  logic             win_hit,
  output line_state_e      state,
  output logic [CNT_W-1:0] count,
  output logic             flip
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  line_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (win_last) begin
      if (win_hit) cnt_d = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
      else         cnt_d = (cnt_q == '0)      ? cnt_q : cnt_q - 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    if (win_last) begin
      if (state_q == LINE_BAD  && cnt_d == '0)      state_d = LINE_GOOD;
      if (state_q == LINE_GOOD && cnt_d == CNT_TOP) state_d = LINE_BAD;
    end
  end

  assign flip  = (state_d != state_q);
  assign state = state_q;
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LINE_BAD;
      cnt_q   <= CNT_TOP;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/lqm_irq_pulse.sv
module lqm_irq_pulse (
  input  logic clk,
  input  logic rst,
  input  logic flip,
  input  logic enable,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= flip & enable;
  end
endmodule

// File: rtl/line_quality_monitor.sv
module line_quality_monitor
  import lqm_pkg::*;
#(
  parameter int WIN_CYCLES = 1024,
  parameter int CNT_W      = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bad_sym,
  input  logic                irq_en,
  output logic                line_good,
  output logic [STATUS_W-1:0] status_word,
  output logic [CNT_W-1:0]    win_count,
  output logic                irq
);
  logic        win_last;
  logic        win_hit;
  logic        flip;
  line_state_e state;

  lqm_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .win_last (win_last)
  );

  lqm_hit_tracker u_hits (
    .clk      (clk),
    .rst      (rst),
    .bad_sym  (bad_sym),
    .win_last (win_last),
    .win_hit  (win_hit)
  );

  lqm_hysteresis #(.CNT_W(CNT_W)) u_hyst (
    .clk      (clk),
    .rst      (rst),
    .win_last (win_last),
    .win_hit  (win_hit),
    .state    (state),
    .count    (win_count),
    .flip     (flip)
  );

  lqm_irq_pulse u_irq (
    .clk    (clk),
    .rst    (rst),
    .flip   (flip),
    .enable (irq_en),
    .irq    (irq)
  );

  assign line_good = (state == LINE_GOOD);

  always_comb begin
    status_word = '0;
    status_word[GOOD_BIT_POS] = line_good;
  end
endmodule

// File: rtl/lqm_checker.sv
module lqm_checker #(
  parameter int WIN_CYCLES = 1024,
  parameter int CNT_W      = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_en,
  input logic             line_good,
  input logic [7:0]       status_word,
  input logic [CNT_W-1:0] win_count,
  input logic             irq
);
  localparam int TW = $clog2(WIN_CYCLES) + 1;
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // Independent cycle position: 0 right after each window's closing edge.
  logic [TW-1:0] ph_q;
  always_ff @(posedge clk) begin
    if (rst)                                ph_q <= '0;
    else if (ph_q == TW'(WIN_CYCLES - 1))   ph_q <= '0;
    else                                    ph_q <= ph_q + 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!line_good && win_count == TOP && !irq && status_word == 8'h00));

  a_r2_window_boundary: assert property (@(posedge clk) disable iff (rst)
    (win_count != $past(win_count)) |-> (ph_q == '0));

  a_r3_r4_unit_step: assert property (@(posedge clk) disable iff (rst)
    (win_count != $past(win_count)) |->
      (win_count == $past(win_count) + 1'b1 || win_count + 1'b1 == $past(win_count)));

  a_r5_good_at_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(line_good) |-> (win_count == '0));

  a_r6_bad_at_top: assert property (@(posedge clk) disable iff (rst)
    $fell(line_good) |-> (win_count == TOP));

  a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  a_r7_irq_on_flip: assert property (@(posedge clk) disable iff (rst)
    irq |-> (line_good != $past(line_good)));

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
    ((line_good != $past(line_good)) && !$past(irq_en)) |-> !irq);

  a_r10_status_bit: assert property (@(posedge clk) disable iff (rst)
    (status_word[6] == line_good) && ((status_word & 8'hBF) == 8'h00));
endmodule

bind line_quality_monitor lqm_checker #(
  .WIN_CYCLES (WIN_CYCLES),
  .CNT_W      (CNT_W)
) u_lqm_checker (
  .clk         (clk),
  .rst         (rst),
  .irq_en      (irq_en),
  .line_good   (line_good),
  .status_word (status_word),
  .win_count   (win_count),
  .irq         (irq)
);

// File: tb/line_quality_monitor_bench.sv
module line_quality_monitor_bench;
  localparam int WIN = 16;
  localparam int NV  = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bad_sym = 1'b0;
  logic       irq_en = 1'b1;
  logic       line_good;
  logic [7:0] status_word;
  logic [2:0] win_count;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  line_quality_monitor #(.WIN_CYCLES(WIN), .CNT_W(3)) u_line_quality_monitor (
    .clk         (clk),
    .rst         (rst),
    .bad_sym     (bad_sym),
    .irq_en      (irq_en),
    .line_good   (line_good),
    .status_word (status_word),
    .win_count   (win_count),
    .irq         (irq)
  );

  // Row layout {pattern, count, status, irq}; pattern 0 clean, 1 strobe on
  // first edge, 2 strobe on last edge, 3 strobe mid-window.
  localparam logic [6:0] VEC [NV] = '{
    {2'd0, 3'd6, 1'b0, 1'b0},
    {2'd2, 3'd7, 1'b0, 1'b0},  // R9: last-edge strobe counts here
    {2'd0, 3'd6, 1'b0, 1'b0},  // R9: and not in this window
    {2'd0, 3'd5, 1'b0, 1'b0},
    {2'd0, 3'd4, 1'b0, 1'b0},
    {2'd0, 3'd3, 1'b0, 1'b0},
    {2'd0, 3'd2, 1'b0, 1'b0},
    {2'd0, 3'd1, 1'b0, 1'b0},
    {2'd0, 3'd0, 1'b1, 1'b1},
    {2'd0, 3'd0, 1'b1, 1'b0},
    {2'd1, 3'd1, 1'b1, 1'b0},
    {2'd0, 3'd0, 1'b1, 1'b0},
    {2'd3, 3'd1, 1'b1, 1'b0},
    {2'd1, 3'd2, 1'b1, 1'b0},
    {2'd2, 3'd3, 1'b1, 1'b0},
    {2'd3, 3'd4, 1'b1, 1'b0},
    {2'd1, 3'd5, 1'b1, 1'b0},
    {2'd2, 3'd6, 1'b1, 1'b0},
    {2'd3, 3'd7, 1'b0, 1'b1},
    {2'd1, 3'd7, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Called at a falling edge; leaves the bench at the falling edge after the
  // window's closing rising edge.
  task automatic run_window(input logic [1:0] pat);
    for (int i = 0; i < WIN; i++) begin
      bad_sym = (pat == 2'd1 && i == 0) || (pat == 2'd2 && i == WIN - 1) ||
                (pat == 2'd3 && i == WIN / 2);
      @(negedge clk);
    end
    bad_sym = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bad_sym = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 count", win_count, 7);
    check("R1 status", line_good, 0);
    check("R1 irq", irq, 0);
    check("R10 word after reset", status_word, 8'h00);

    for (int r = 0; r < NV; r++) begin
      run_window(VEC[r][6:5]);
      check($sformatf("R3 R4 count row %0d", r), win_count, VEC[r][4:2]);
      check($sformatf("R5 R6 status row %0d", r), line_good, VEC[r][1]);
      check($sformatf("R7 irq row %0d", r), irq, VEC[r][0]);
    end

    // R8: mask the interrupt and reach good status
    do_reset();
    irq_en = 1'b0;
    for (int w = 0; w < 7; w++) run_window(2'd0);
    check("R8 status flips", line_good, 1);
    check("R8 irq masked", irq, 0);
    check("R10 word good", status_word, 8'h40);
    @(negedge clk);
    check("R8 irq stays low", irq, 0);
    irq_en = 1'b1;

    // R1 R2: reset mid-window discards the partial window
    do_reset();
    bad_sym = 1'b1;
    repeat (5) @(negedge clk);
    bad_sym = 1'b0;
    do_reset();
    check("R1 reset mid-window", win_count, 7);
    repeat (WIN - 1) @(negedge clk);
    check("R2 no change before window end", win_count, 7);
    @(negedge clk);
    check("R2 change at window end", win_count, 6);
    for (int w = 0; w < 5; w++) run_window(2'd0);
    check("R5 count one", win_count, 1);
    run_window(2'd0);
    check("R5 good", line_good, 1);
    check("R7 irq pulse", irq, 1);
    @(negedge clk);
    check("R7 irq one cycle", irq, 0);
    check("R5 count held", win_count, 0);

    finish_run();
  end
endmodule